// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It walks page tables held in main memory, starting from a context pointer and a context number. The virtual address splits into an 8-bit region index (bits 31:24), a 6-bit segment index (bits 23:18), a 6-bit page index (bits 17:12) and a 12-bit byte offset. The walk fetches one context entry, then one region, one segment and one page table entry. Each of these reads goes out over a memory port that allows one request at a time and uses a request/acknowledge handshake. The final entry supplies the physical page number, a cacheable flag and a 3-bit access code. The walker checks the access code against the access kind and the privilege mode. When the referenced or modified flag in the entry has to change, it writes the updated entry back to the same address.

The block is built around one state machine. `S_IDLE` waits for `start`, and `S_IDLE -> S_CTX` latches the request. On each acknowledged read, a level state either moves to the next level when the entry is a descriptor (`S_CTX -> S_RGN -> S_SEG -> S_PAGE`) or returns to `S_IDLE` with a fault. `S_PAGE` has three exits:

- back to `S_IDLE` with a protection fault;
- back to `S_IDLE` with a translation, when no flag changes;
- on to `S_UPDATE`, which writes the entry back and then goes to `S_IDLE` with the translation.

Every completion is reported by a one-cycle pulse on `walk_done` or `walk_fault`.

Top module: `xlat_walker`

## Requirements
- R1: During reset and afterwards until the first `start`, `busy`, `mem_req`, `walk_done` and `walk_fault` are all low.
- R2: The first read of a walk goes to address (`ctx_ptr` with bits 1:0 cleared) * 16 + `ctx_num` * 4.
- R3: The type field is bits 1:0 of each entry: 0 invalid, 1 descriptor, 2 leaf entry, 3 reserved. A descriptor (type 1) at the context, region or segment level leads to a read at (descriptor with bits 1:0 cleared) * 16 + index * 4. The index is va[31:24] after the context level, va[23:18] after the region level and va[17:12] after the segment level.
- R4: A type 0 entry at any level ends the walk with a fault of kind 0. `fault_level` reports the level that stopped the walk: 0 context, 1 region, 2 segment, 3 page.
- R5: A type 3 entry ends the walk with a fault of kind 1. A type 2 entry at the context, region or segment level, or a type 1 entry at the page level, ends the walk with a fault of kind 2.
- R6: Access kind is 0 read, 1 write, 2 execute, 3 read. The leaf access code (bits 4:2) grants the following rights, written as user/supervisor:

  | Code | User | Supervisor |
  |---|---|---|
  | 0 | R | R |
  | 1 | RW | RW |
  | 2 | RX | RX |
  | 3 | RWX | RWX |
  | 4 | X | X |
  | 5 | R | RW |
  | 6 | none | RX |
  | 7 | none | RWX |

  An access that the code does not grant to the current mode faults with kind 3 at level 3.
- R7: On success, `phys_addr` is leaf bits 31:8 shifted left by 12, ORed with va[11:0]. `cacheable` is leaf bit 7.
- R8: On success the referenced bit (bit 5) is set, and for a write the modified bit (bit 6) is also set. The walker writes the entry back to its own address only if this changes it. The reported translation is taken from the updated entry.
- R9: One memory request is outstanding at a time. `mem_req`, `mem_addr` and `mem_we` stay unchanged from when the request is raised until the cycle it is acknowledged.
- R10: `start` is ignored while `busy` is high. It neither changes the walk in progress nor starts another walk afterwards.
- R11: `walk_done` and `walk_fault` are one-cycle pulses and are never high together. `busy` is low in the cycle they are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled only when idle) |
| va | input | 32 | Virtual address to translate |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| user_mode | input | 1 | 1 for a user-mode access, 0 for supervisor |
| ctx_ptr | input | 32 | Context table pointer (address / 16) |
| ctx_num | input | CTX_W | Current context number |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr | output | 36 | Byte address of the table entry |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| walk_done | output | 1 | Successful translation pulse |
| walk_fault | output | 1 | Fault pulse |
| fault_level | output | 2 | Level where the walk stopped |
| fault_kind | output | 2 | 0 invalid, 1 reserved, 2 wrong type, 3 protection |
| phys_addr | output | 36 | Translated physical address |
| cacheable | output | 1 | Cacheable flag of the translation |

## Verification
The bench builds the walker with `CTX_W` = 4. This makes the highest context number, 15, a cheap case, and it exercises the zero-extension of a narrow context field into the address adder. The memory model's acknowledge latency is varied from zero to three wait cycles. This tests the hold-until-acknowledge rule and an intruding `start` over long waits as well as back-to-back accesses. A sweep over all eight access codes, both modes and all three access kinds reaches every grant and denial. Separate walks cover each of the three type faults at the table levels where each can occur.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int VA_W   = 32;
    localparam int ENT_W  = 32;
    localparam int OFF_W  = 12;
    localparam int PPN_W  = ENT_W - 8;
    localparam int PA_W   = PPN_W + OFF_W;

    localparam int RGN_LO = 24;
    localparam int SEG_LO = 18;
    localparam int PG_LO  = OFF_W;

    localparam int B_CACHE = 7;
    localparam int B_MOD   = 6;
    localparam int B_REF   = 5;

    localparam logic [1:0] TY_INVALID = 2'd0;
    localparam logic [1:0] TY_DESC    = 2'd1;
    localparam logic [1:0] TY_LEAF    = 2'd2;
    localparam logic [1:0] TY_RSVD    = 2'd3;

    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTX,
        S_RGN,
        S_SEG,
        S_PAGE,
        S_UPDATE
    } walk_state_e;

    typedef enum logic [1:0] {
        FK_INVALID   = 2'd0,
        FK_RESERVED  = 2'd1,
        FK_MISPLACED = 2'd2,
        FK_PROT      = 2'd3
    } fault_kind_e;

    // Classify an entry whose type is not the one the current level expects.
    function automatic fault_kind_e type_fault(input logic [1:0] ty);
        fault_kind_e k;
        unique case (ty)
            TY_INVALID: k = FK_INVALID;
            TY_RSVD:    k = FK_RESERVED;
            default:    k = FK_MISPLACED;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [1:0]       level,
    input  logic [VA_W-1:0]  va,
    input  logic [ENT_W-1:0] ctx_ptr,
    input  logic [CTX_W-1:0] ctx_num,
    input  logic [ENT_W-1:0] desc,
    output logic [PA_W-1:0]  addr
);
    localparam int BASE_SH = PA_W - ENT_W;

    logic [ENT_W-1:0] base_src;
    logic [PA_W-1:0]  word_idx;

    always_comb begin
        base_src = desc;
        word_idx = '0;
        unique case (level)
            2'd0: begin
                base_src = ctx_ptr;
                word_idx = PA_W'(ctx_num);
            end
            2'd1:    word_idx = PA_W'(va[VA_W-1:RGN_LO]);
            2'd2:    word_idx = PA_W'(va[RGN_LO-1:SEG_LO]);
            default: word_idx = PA_W'(va[SEG_LO-1:PG_LO]);
        endcase
    end

    // Table base: pointer with the type bits cleared, widened to a byte address.
    always_comb begin
        addr = {(base_src & ~ENT_W'(3)), BASE_SH'(0)} + (word_idx << 2);
    end

endmodule

// File: rtl/xw_perm_check.sv
module xw_perm_check
    import xw_pkg::*;
(
    input  logic [2:0] code,
    input  logic       user,
    input  logic [1:0] kind,
    output logic       allow
);
    // Rights vectors: bit 2 read, bit 1 write, bit 0 execute.
    logic [2:0] usr_rwx;
    logic [2:0] sup_rwx;
    logic [2:0] need;

    always_comb begin
        unique case (code)
            3'd0: begin usr_rwx = 3'b100; sup_rwx = 3'b100; end
            3'd1: begin usr_rwx = 3'b110; sup_rwx = 3'b110; end
            3'd2: begin usr_rwx = 3'b101; sup_rwx = 3'b101; end
            3'd3: begin usr_rwx = 3'b111; sup_rwx = 3'b111; end
            3'd4: begin usr_rwx = 3'b001; sup_rwx = 3'b001; end
            3'd5: begin usr_rwx = 3'b100; sup_rwx = 3'b110; end
            3'd6: begin usr_rwx = 3'b000; sup_rwx = 3'b101; end
            default: begin usr_rwx = 3'b000; sup_rwx = 3'b111; end
        endcase

        unique case (kind)
            ACC_WRITE: need = 3'b010;
            ACC_EXEC:  need = 3'b001;
            default:   need = 3'b100;
        endcase

        allow = |(need & (user ? usr_rwx : sup_rwx));
    end

endmodule

// File: rtl/xw_entry_update.sv
module xw_entry_update
    import xw_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    output logic [ENT_W-1:0] entry_new,
    output logic             changed
);
    always_comb begin
        entry_new        = entry;
        entry_new[B_REF] = 1'b1;
        if (is_write) begin
            entry_new[B_MOD] = 1'b1;
        end
        changed = (entry_new != entry);
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       va,
    input  logic [1:0]        acc_kind,
    input  logic              user_mode,
    input  logic [31:0]       ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [35:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              walk_done,
    output logic              walk_fault,
    output logic [1:0]        fault_level,
    output logic [1:0]        fault_kind,
    output logic [35:0]       phys_addr,
    output logic              cacheable
);

    walk_state_e state, nxt;

    logic [VA_W-1:0]  va_q;
    logic [ENT_W-1:0] ptr_q;
    logic [CTX_W-1:0] ctx_q;
    logic [1:0]       kind_q;
    logic             user_q;
    logic [ENT_W-1:0] desc_q;
    logic [ENT_W-1:0] pte_q;

    logic [1:0]       lvl;
    logic [1:0]       ety;
    logic             allow;
    logic [ENT_W-1:0] upd_pte;
    logic             upd_chg;
    logic [PA_W-1:0]  gen_addr;

    logic             fire_done;
    logic             fire_fault;
    logic             load_desc;
    logic             load_pte;
    fault_kind_e      fk;

    logic [PPN_W-1:0] res_ppn;
    logic             res_c;

    // Table level addressed by the current state.
    always_comb begin
        unique case (state)
            S_CTX:   lvl = 2'd0;
            S_RGN:   lvl = 2'd1;
            S_SEG:   lvl = 2'd2;
            default: lvl = 2'd3;
        endcase
    end

    xw_addr_gen #(.CTX_W(CTX_W)) u_addr (
        .level   (lvl),
        .va      (va_q),
        .ctx_ptr (ptr_q),
        .ctx_num (ctx_q),
        .desc    (desc_q),
        .addr    (gen_addr)
    );

    xw_perm_check u_perm (
        .code  (mem_rdata[4:2]),
        .user  (user_q),
        .kind  (kind_q),
        .allow (allow)
    );

    xw_entry_update u_upd (
        .entry     (mem_rdata),
        .is_write  (kind_q == ACC_WRITE),
        .entry_new (upd_pte),
        .changed   (upd_chg)
    );

    // Next-state and event decode.
    always_comb begin
        nxt        = state;
        fire_done  = 1'b0;
        fire_fault = 1'b0;
        fk         = FK_INVALID;
        load_desc  = 1'b0;
        load_pte   = 1'b0;
        ety        = mem_rdata[1:0];
        unique case (state)
            S_IDLE: begin
                if (start) nxt = S_CTX;
            end
            S_CTX, S_RGN, S_SEG: begin
                if (mem_ack) begin
                    if (ety == TY_DESC) begin
                        load_desc = 1'b1;
                        if (state == S_CTX)      nxt = S_RGN;
                        else if (state == S_RGN) nxt = S_SEG;
                        else                     nxt = S_PAGE;
                    end else begin
                        fire_fault = 1'b1;
                        fk         = type_fault(ety);
                        nxt        = S_IDLE;
                    end
                end
            end
            S_PAGE: begin
                if (mem_ack) begin
                    if (ety != TY_LEAF) begin
                        fire_fault = 1'b1;
                        fk         = type_fault(ety);
                        nxt        = S_IDLE;
                    end else if (!allow) begin
                        fire_fault = 1'b1;
                        fk         = FK_PROT;
                        nxt        = S_IDLE;
                    end else if (upd_chg) begin
                        load_pte = 1'b1;
                        nxt      = S_UPDATE;
                    end else begin
                        fire_done = 1'b1;
                        nxt       = S_IDLE;
                    end
                end
            end
            S_UPDATE: begin
                if (mem_ack) begin
                    fire_done = 1'b1;
                    nxt       = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State register and walk context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            va_q   <= '0;
            ptr_q  <= '0;
            ctx_q  <= '0;
            kind_q <= '0;
            user_q <= 1'b0;
            desc_q <= '0;
            pte_q  <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                va_q   <= va;
                ptr_q  <= ctx_ptr;
                ctx_q  <= ctx_num;
                kind_q <= acc_kind;
                user_q <= user_mode;
            end
            if (load_desc) desc_q <= mem_rdata;
            if (load_pte)  pte_q  <= upd_pte;
        end
    end

    // Translation source: the written-back entry, or the updated read data.
    always_comb begin
        if (state == S_UPDATE) begin
            res_ppn = pte_q[ENT_W-1:8];
            res_c   = pte_q[B_CACHE];
        end else begin
            res_ppn = upd_pte[ENT_W-1:8];
            res_c   = upd_pte[B_CACHE];
        end
    end

    // Registered completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_done   <= 1'b0;
            walk_fault  <= 1'b0;
            fault_level <= '0;
            fault_kind  <= '0;
            phys_addr   <= '0;
            cacheable   <= 1'b0;
        end else begin
            walk_done  <= fire_done;
            walk_fault <= fire_fault;
            if (fire_done) begin
                phys_addr <= {res_ppn, va_q[OFF_W-1:0]};
                cacheable <= res_c;
            end
            if (fire_fault) begin
                fault_level <= lvl;
                fault_kind  <= fk;
            end
        end
    end

    // Memory port outputs.
    always_comb begin
        busy      = (state != S_IDLE);
        mem_req   = (state != S_IDLE);
        mem_we    = (state == S_UPDATE);
        mem_addr  = gen_addr;
        mem_wdata = pte_q;
    end

    // R9: a pending request holds its address and direction until acknowledged.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: completion flags are single-cycle pulses.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done || walk_fault) |=> !(walk_done || walk_fault));

    // R11: success and fault never coincide, and the walker is idle then.
    p_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done || walk_fault) |-> (!(walk_done && walk_fault) && !busy));

    // R8: any write-back carries the referenced flag.
    p_wb_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[B_REF]);

    // R6: protection faults come only from the page level.
    p_prot_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_fault && fault_kind == FK_PROT) |-> (fault_level == 2'd3));

    // R7: the byte offset passes through untouched.
    p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> (phys_addr[OFF_W-1:0] == va_q[OFF_W-1:0]));

endmodule

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;

    localparam int CW = 4;
    localparam bit [35:0] RB = 36'h2_0000;
    localparam bit [35:0] SB = 36'h3_0000;
    localparam bit [35:0] PB = 36'h4_0000;
    localparam bit [31:0] PTR = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   va_i = '0;
    logic [1:0]    kind_i = '0;
    logic          user_i = 1'b0;
    logic [31:0]   ptr_i = '0;
    logic [CW-1:0] ctx_i = '0;
    logic          busy, mem_req, mem_we, mem_ack = 1'b0;
    logic [35:0]   mem_addr, phys_addr;
    logic [31:0]   mem_wdata, mem_rdata = '0;
    logic          walk_done, walk_fault, cacheable;
    logic [1:0]    fault_level, fault_kind;

    xlat_walker #(.CTX_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .va(va_i), .acc_kind(kind_i),
        .user_mode(user_i), .ctx_ptr(ptr_i), .ctx_num(ctx_i), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .walk_done(walk_done), .walk_fault(walk_fault), .fault_level(fault_level),
        .fault_kind(fault_kind), .phys_addr(phys_addr), .cacheable(cacheable)
    );

    always #4 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int lat = 0;
    int wait_cnt = 0;
    bit active = 0;
    bit finished = 0;
    bit prev_pend = 0;
    bit [35:0] prev_addr = '0;

    bit [31:0] mem [bit [35:0]];

    bit [35:0] q_addr[$];
    bit        q_we[$];
    bit [31:0] q_wd[$];
    string     q_tag[$];
    bit        exp_fault;
    bit [1:0]  exp_lvl, exp_kind;
    bit [35:0] exp_pa;
    bit        exp_c;
    string     exp_tag;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] rd(input bit [35:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    function automatic bit granted(input int code, input bit u, input bit [1:0] k);
        if (k == 2'd1) return u ? (code inside {1, 3}) : (code inside {1, 3, 5, 7});
        if (k == 2'd2) return u ? (code inside {2, 3, 4}) : (code inside {2, 3, 4, 6, 7});
        return u ? (code inside {0, 1, 2, 3, 5}) : (code inside {0, 1, 2, 3, 5, 6, 7});
    endfunction

    function automatic bit [35:0] ctx_at(input bit [31:0] p, input int cn);
        return 36'(p & ~32'h3) * 16 + 36'(cn * 4);
    endfunction

    function automatic bit [31:0] dsc(input bit [35:0] base);
        return 32'(base / 16) | 32'h1;
    endfunction

    // Reference walk: fills the expected access list and result.
    task automatic predict(input bit [31:0] v, input bit [1:0] k, input bit u, input bit [31:0] p, input int cn);
        bit [35:0] a;
        bit [31:0] e, ne;
        int idx[4];
        idx[1] = int'(v / 32'h0100_0000);
        idx[2] = int'((v / 32'h4_0000) % 64);
        idx[3] = int'((v / 32'h1000) % 64);
        a = ctx_at(p, cn);
        q_addr.delete(); q_we.delete(); q_wd.delete(); q_tag.delete();
        for (int l = 0; l < 4; l++) begin
            q_addr.push_back(a); q_we.push_back(1'b0); q_wd.push_back(32'h0);
            q_tag.push_back(l == 0 ? "R2" : "R3");
            e = rd(a);
            if (l < 3) begin
                if (e % 4 != 1) begin
                    exp_fault = 1; exp_lvl = 2'(l);
                    exp_kind = (e % 4 == 0) ? 2'd0 : (e % 4 == 3) ? 2'd1 : 2'd2;
                    exp_tag = (e % 4 == 0) ? "R4" : "R5";
                    return;
                end
                a = 36'(e & ~32'h3) * 16 + 36'(idx[l+1] * 4);
            end else begin
                if (e % 4 != 2) begin
                    exp_fault = 1; exp_lvl = 2'd3;
                    exp_kind = (e % 4 == 0) ? 2'd0 : (e % 4 == 3) ? 2'd1 : 2'd2;
                    exp_tag = (e % 4 == 0) ? "R4" : "R5";
                    return;
                end
                if (!granted(int'((e / 4) % 8), u, k)) begin
                    exp_fault = 1; exp_lvl = 2'd3; exp_kind = 2'd3; exp_tag = "R6";
                    return;
                end
                ne = e | 32'h20 | ((k == 2'd1) ? 32'h40 : 32'h0);
                if (ne != e) begin
                    q_addr.push_back(a); q_we.push_back(1'b1); q_wd.push_back(ne); q_tag.push_back("R8");
                end
                exp_fault = 0;
                exp_pa = 36'(ne / 256) * 36'h1000 + 36'(v % 32'h1000);
                exp_c = ne[7];
                exp_tag = "R7";
            end
        end
    endtask

    // Memory responder, per-clock comparison and watchdog.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
        if (!rst_n) begin
            mem_ack = 1'b0; wait_cnt = 0; prev_pend = 0;
        end else begin
            if (prev_pend) begin
                chk("R9", "request held", {63'd0, mem_req}, 64'd1);
                chk("R9", "address held", {28'd0, mem_addr}, {28'd0, prev_addr});
            end
            if (mem_req && !active) chk("R10", "request outside walk", 64'd1, 64'd0);
            if (walk_done || walk_fault) begin
                chk("R11", "busy at completion", {63'd0, busy}, 64'd0);
                chk("R11", "single flag", {63'd0, walk_done && walk_fault}, 64'd0);
                if (!active) chk("R11", "completion without walk", 64'd1, 64'd0);
                chk(exp_tag, "fault flag", {63'd0, walk_fault}, {63'd0, exp_fault});
                if (exp_fault) begin
                    chk(exp_tag, "fault level", {62'd0, fault_level}, {62'd0, exp_lvl});
                    chk(exp_tag, "fault kind", {62'd0, fault_kind}, {62'd0, exp_kind});
                end else begin
                    chk("R7", "physical address", {28'd0, phys_addr}, {28'd0, exp_pa});
                    chk("R7", "cacheable", {63'd0, cacheable}, {63'd0, exp_c});
                end
                chk("R8", "accesses left", 64'(q_addr.size()), 64'd0);
                active = 0; finished = 1;
            end
            if (mem_ack) begin
                mem_ack = 1'b0; wait_cnt = 0;
            end else if (mem_req) begin
                if (wait_cnt >= lat) begin
                    if (q_addr.size() == 0) begin
                        chk("R3", "unexpected access", {28'd0, mem_addr}, 64'd0);
                    end else begin
                        chk(q_tag[0], "access address", {28'd0, mem_addr}, {28'd0, q_addr[0]});
                        chk(q_tag[0], "access direction", {63'd0, mem_we}, {63'd0, q_we[0]});
                        if (q_we[0]) chk("R8", "write-back data", {32'd0, mem_wdata}, {32'd0, q_wd[0]});
                        void'(q_addr.pop_front()); void'(q_we.pop_front());
                        void'(q_wd.pop_front()); void'(q_tag.pop_front());
                    end
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else mem_rdata = rd(mem_addr);
                    mem_ack = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
            prev_pend = mem_req && !mem_ack;
            prev_addr = mem_addr;
        end
    end

    task automatic map(input int cn, input bit [31:0] v, input bit [31:0] leaf);
        mem[ctx_at(PTR, cn)] = dsc(RB);
        mem[RB + 36'(v[31:24]) * 4] = dsc(SB);
        mem[SB + 36'(v[23:18]) * 4] = dsc(PB);
        mem[PB + 36'(v[17:12]) * 4] = leaf;
    endtask

    function automatic bit [31:0] leaf(input bit [23:0] ppn, input bit c, input bit m, input bit r, input int code);
        return {ppn, c, m, r, 3'(code), 2'd2};
    endfunction

    task automatic walk(input bit [31:0] v, input bit [1:0] k, input bit u, input int cn, input int l, input bit intrude);
        predict(v, k, u, PTR, cn);
        lat = l; active = 1; finished = 0;
        va_i = v; kind_i = k; user_i = u; ptr_i = PTR; ctx_i = CW'(cn); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (intrude) begin
            @(negedge clk); start = 1'b1; va_i = ~v; kind_i = 2'd1; ctx_i = CW'(cn + 1);
            @(negedge clk); start = 1'b0;
        end
        while (!finished) @(negedge clk);
        if (intrude) begin
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                chk("R10", "idle after ignored start", {63'd0, mem_req || busy}, 64'd0);
            end
        end
    endtask

    initial begin
        bit [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", {63'd0, busy}, 64'd0);
        chk("R1", "request in reset", {63'd0, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", {63'd0, busy}, 64'd0);
        chk("R1", "request after reset", {63'd0, mem_req}, 64'd0);
        chk("R1", "done after reset", {63'd0, walk_done}, 64'd0);
        chk("R1", "fault after reset", {63'd0, walk_fault}, 64'd0);

        // R8: first read sets referenced bit, second finds nothing to change.
        v = 32'hA5C4_3123;
        map(3, v, leaf(24'hABCDE1, 1, 0, 0, 0));
        walk(v, 2'd0, 0, 3, 0, 0);
        walk(v, 2'd0, 0, 3, 1, 0);
        // R8: user write sets modified, then repeat is silent.
        v = 32'h0104_7FFF;
        map(15, v, leaf(24'h00F00F, 0, 0, 1, 1));
        walk(v, 2'd1, 1, 15, 2, 0);
        walk(v, 2'd1, 1, 15, 0, 0);
        // R6: selected grants and denials; kind 3 is a read.
        v = 32'hFFFF_F000;
        map(0, v, leaf(24'hFFFFFF, 1, 1, 1, 4));
        walk(v, 2'd2, 1, 0, 1, 0);
        walk(v, 2'd0, 0, 0, 1, 0);
        walk(v, 2'd3, 1, 0, 0, 0);
        map(0, v, leaf(24'h123456, 1, 0, 1, 6));
        walk(v, 2'd0, 1, 0, 0, 0);
        walk(v, 2'd2, 0, 0, 3, 0);
        map(0, v, leaf(24'h000001, 0, 0, 1, 5));
        walk(v, 2'd1, 0, 0, 0, 0);
        walk(v, 2'd1, 1, 0, 0, 0);
        // R4: missing context entry.
        walk(32'h1234_5678, 2'd0, 0, 7, 1, 0);
        // R5: reserved region entry, leaf at segment level, descriptor at page level.
        v = 32'h3300_4000;
        map(2, v, leaf(24'h000100, 1, 0, 1, 3));
        mem[RB + 36'(v[31:24]) * 4] = 32'h0000_0003;
        walk(v, 2'd0, 0, 2, 0, 0);
        map(2, v, leaf(24'h000100, 1, 0, 1, 3));
        mem[SB + 36'(v[23:18]) * 4] = 32'h0000_0102;
        walk(v, 2'd0, 0, 2, 2, 0);
        map(2, v, dsc(PB));
        walk(v, 2'd0, 0, 2, 0, 0);
        // R4: invalid leaf.
        map(2, v, 32'hFFFF_FF00);
        walk(v, 2'd0, 0, 2, 1, 0);
        // R10: start raised mid-walk is ignored.
        v = 32'h7E9D_2ABC;
        map(5, v, leaf(24'h0BEEF0, 1, 0, 0, 3));
        walk(v, 2'd0, 0, 5, 3, 1);
        // R6/R7/R8 sweep over every code, mode and access kind.
        for (int code = 0; code < 8; code++) begin
            for (int u = 0; u < 2; u++) begin
                for (int k = 0; k < 3; k++) begin
                    v = {8'(code * 17 + k), 6'(u * 5 + code), 6'(k * 7), 12'(code * 100 + k)};
                    map(code + u, v, leaf(24'(code * 4099 + k), code[0], 0, 1, code));
                    walk(v, 2'(k), u[0], code + u, (code + k) % 4, 0);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule